// File: doc/BRIEF.md
# Serial Control-Register Port

This block is a serial slave port. It gives an external host read and write access to a bank of sixteen 8-bit control registers. The host frames every access with an active-low select. It then sends exactly sixteen serial clock periods: a command byte and then a data byte, each MSB first. The command byte holds a read flag in its top bit, three don't-care bits and a 4-bit register address. In a write, the second byte is the value to store. In a read, the block returns the addressed register on a serial output that acts as open drain. The block can only pull that line low or let it go, and an external pull-up supplies the ones.

The serial clock, data and select pins are sampled by a faster system clock. Each pin passes through a two-flop synchronizer, and edges are found by comparing each new sample with the one before it. A frame state machine has four states: `ST_IDLE`, `ST_CMD`, `ST_DATA` and `ST_DONE`. Its transitions are:
- `ST_IDLE` goes to `ST_CMD` on the falling edge of select.
- `ST_CMD` goes to `ST_DATA` on the 8th serial-clock rise.
- `ST_DATA` goes to `ST_DONE` on the 16th rise, which is also when a write commits.
- Any active state goes back to `ST_IDLE` when select goes high. This return is the abort path when fewer than 16 bits have arrived.

The register contents are presented in parallel for the logic they control. The address of the last complete command byte is also made visible.

Top module: `spi_regport`

## Requirements
- R1: A frame is the bits sampled on serial-clock rising edges while select is low. Bits 1 to 8 form the command byte, MSB first, and bits 9 to 16 form the data byte, MSB first. Command bit 7 set means read and clear means write. Command bits 3:0 are the register address.
- R2: In a write, the data byte is stored into register `addr` when the 16th bit is received with select still low. The new value then appears on `reg_flat[8*addr+7 : 8*addr]`.
- R3: In a read, the addressed register is presented MSB first. Its first bit appears at the 8th serial-clock falling edge and its last bit at the 15th, so the host can sample them on rises 9 to 16. `sdo_pull_low` = 1 means the line is driven low, and 0 means the line is released and reads as 1.
- R4: `sdo_pull_low` is 0 whenever select is high, and it stays 0 for the whole of any write frame.
- R5: After the 16th serial-clock falling edge of a read, `sdo_pull_low` returns to 0 even while select stays low.
- R6: After reset, all registers read 00h, `addr_now` is 0 and `sdo_pull_low` is 0.
- R7: If select rises before 16 bits have arrived, no register changes. The next frame is then decoded from its first bit.
- R8: Command bits 6:4 are ignored. A frame whose reserved bits are not zero performs the same access as one with zero reserved bits.
- R9: Serial-clock edges after the 16th, within the same select window, change no register and do not drive the output.
- R10: `addr_now` takes the address field when a command byte completes, and it holds that value until the next command byte completes. An abort before bit 8 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_pin | input | 1 | Serial clock from host, idles low |
| sdi_pin | input | 1 | Serial data from host |
| csn_pin | input | 1 | Active-low frame select |
| sdo_pull_low | output | 1 | 1 = pad pulls data-out low, 0 = released |
| addr_now | output | 4 | Address from the last completed command byte |
| reg_flat | output | 128 | All registers, register n in bits 8n+7:8n |

## Verification
Writes and reads are exercised with asymmetric data such as 16h and C1h. Any swap of bit order or byte order gives a different value, while a symmetric value like 5Ah would hide it. All-zero and mixed patterns on readback show that the output is pulled low only for zero bits and let go after the last bit. Frames with reserved command bits set are compared with clean frames, so address decoding that looks at bits 6:4 is caught. Short frames, cut at 4 and at 12 bits, and long frames of 20 bits separate correct commit-on-16th behaviour from commit-on-select-rise or commit-on-any-edge designs.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMD  = 2'd1,
        ST_DATA = 2'd2,
        ST_DONE = 2'd3
    } frame_state_t;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_sync
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= RST_VAL;
                    else        stage_q[s] <= pin_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= RST_VAL;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign pin_sync = stage_q[STAGES-1];

endmodule

// File: rtl/spi_frame_fsm.sv
module spi_frame_fsm
    import spi_regport_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              sdi_s,
    input  logic              csn_s,
    input  logic [DATA_W-1:0] rd_byte,
    output logic [ADDR_W-1:0] look_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [ADDR_W-1:0] addr_now,
    output logic              drive_q
);

    localparam int FRAME_BITS = 2 * DATA_W;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] CMD_LAST   = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME_BITS - 1);

    frame_state_t      state, nxt;
    logic              sclk_q, csn_q;
    logic              sclk_rise, sclk_fall, csn_fall;
    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] shift_q;
    logic [DATA_W-1:0] byte_now;
    logic [DATA_W-1:0] rd_shift;
    logic              rd_flag;
    logic [ADDR_W-1:0] addr_q;

    // edge detection on synchronized samples
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            csn_q  <= 1'b1;
        end else begin
            sclk_q <= sclk_s;
            csn_q  <= csn_s;
        end
    end

    assign sclk_rise = sclk_s & ~sclk_q;
    assign sclk_fall = ~sclk_s & sclk_q;
    assign csn_fall  = ~csn_s & csn_q;
    assign byte_now  = {shift_q[DATA_W-2:0], sdi_s};

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (csn_fall) nxt = ST_CMD;
            ST_CMD: begin
                if (csn_s)                                nxt = ST_IDLE;
                else if (sclk_rise && bit_cnt == CMD_LAST) nxt = ST_DATA;
            end
            ST_DATA: begin
                if (csn_s)                                  nxt = ST_IDLE;
                else if (sclk_rise && bit_cnt == FRAME_LAST) nxt = ST_DONE;
            end
            ST_DONE: if (csn_s) nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // frame datapath: bit counter, input shifter, command capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            shift_q  <= '0;
            rd_flag  <= 1'b0;
            addr_q   <= '0;
            rd_shift <= '0;
        end else if (state == ST_IDLE || csn_s) begin
            bit_cnt <= '0;
            if (state == ST_IDLE) rd_flag <= 1'b0;
        end else if (state == ST_CMD || state == ST_DATA) begin
            if (sclk_rise) begin
                bit_cnt <= bit_cnt + 1'b1;
                shift_q <= byte_now;
                if (state == ST_CMD && bit_cnt == CMD_LAST) begin
                    rd_flag  <= byte_now[DATA_W-1];
                    addr_q   <= byte_now[ADDR_W-1:0];
                    rd_shift <= rd_byte;
                end
            end else if (sclk_fall && state == ST_DATA && rd_flag) begin
                rd_shift <= {rd_shift[DATA_W-2:0], 1'b0};
            end
        end
    end

    // output process: write strobe and open-drain pull request
    always_comb begin
        look_addr = byte_now[ADDR_W-1:0];
        wr_en     = (state == ST_DATA) && !csn_s && sclk_rise &&
                    (bit_cnt == FRAME_LAST) && !rd_flag;
        wr_addr   = addr_q;
        wr_data   = byte_now;
        addr_now  = addr_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drive_q <= 1'b0;
        end else if (state == ST_IDLE || csn_s) begin
            drive_q <= 1'b0;
        end else if (sclk_fall) begin
            drive_q <= (state == ST_DATA) && rd_flag && !rd_shift[DATA_W-1];
        end
    end

    // R9: counter never passes the frame length
    a_r9_cnt_capped: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(FRAME_BITS));

    // R4: no pull while idle
    a_r4_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !drive_q);

    // R3: pull only during a read frame
    a_r3_pull_only_read: assert property (@(posedge clk) disable iff (!rst_n)
        drive_q |-> rd_flag);

    // R5: a falling edge after the last bit releases the line
    a_r5_done_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE && sclk_fall) |=> !drive_q);

    // R10: address moves only while a command byte is being received
    a_r10_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_CMD) |=> $stable(addr_now));

endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 wr_addr,
    input  logic [DATA_W-1:0]                 wr_data,
    input  logic [ADDR_W-1:0]                 rd_addr,
    output logic [DATA_W-1:0]                 rd_byte,
    output logic [(1<<ADDR_W)*DATA_W-1:0]     reg_flat
);

    localparam int NUM_REGS = 1 << ADDR_W;

    logic [DATA_W-1:0] regs [NUM_REGS];

    generate
        for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    regs[r] <= '0;
                else if (wr_en && wr_addr == ADDR_W'(r))
                    regs[r] <= wr_data;
            end
            assign reg_flat[r*DATA_W +: DATA_W] = regs[r];
        end
    endgenerate

    assign rd_byte = regs[rd_addr];

    // R2: a commit lands in the addressed entry
    a_r2_commit_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (regs[$past(wr_addr)] == $past(wr_data)));

endmodule

// File: rtl/spi_regport.sv
module spi_regport #(
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          sclk_pin,
    input  logic                          sdi_pin,
    input  logic                          csn_pin,
    output logic                          sdo_pull_low,
    output logic [ADDR_W-1:0]             addr_now,
    output logic [(1<<ADDR_W)*DATA_W-1:0] reg_flat
);

    logic [2:0]        pins_s;
    logic [DATA_W-1:0] rd_byte;
    logic [ADDR_W-1:0] look_addr;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic              drive_q;

    spi_pin_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   ({csn_pin, sdi_pin, sclk_pin}),
        .pin_sync (pins_s)
    );

    spi_frame_fsm #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_s    (pins_s[0]),
        .sdi_s     (pins_s[1]),
        .csn_s     (pins_s[2]),
        .rd_byte   (rd_byte),
        .look_addr (look_addr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .addr_now  (addr_now),
        .drive_q   (drive_q)
    );

    spi_reg_bank #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (look_addr),
        .rd_byte  (rd_byte),
        .reg_flat (reg_flat)
    );

    // raw select gates the pad so release is immediate
    assign sdo_pull_low = drive_q & ~csn_pin;

endmodule

// File: tb/test_spi_regport.sv
module test_spi_regport;

    localparam int HALF = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sclk_pin = 1'b0;
    logic         sdi_pin = 1'b0;
    logic         csn_pin = 1'b1;
    logic         sdo_pull_low;
    logic [3:0]   addr_now;
    logic [127:0] reg_flat;

    int n_run  = 0;
    int n_fail = 0;
    logic [7:0] seen;
    logic       tail_pull;

    always #2 clk = ~clk;

    spi_regport i_spi_regport (
        .clk          (clk),
        .rst_n        (rst_n),
        .sclk_pin     (sclk_pin),
        .sdi_pin      (sdi_pin),
        .csn_pin      (csn_pin),
        .sdo_pull_low (sdo_pull_low),
        .addr_now     (addr_now),
        .reg_flat     (reg_flat)
    );

    // {command, data, expected line value during data byte}
    localparam logic [23:0] VEC [0:7] = '{
        24'h0316FF,   // R1 R2 write r3
        24'h0FC1FF,   // R2 write r15
        24'h830016,   // R3 read r3
        24'h8F00C1,   // R3 read r15
        24'h7268FF,   // R8 write r2 with reserved bits set
        24'h820068,   // R8 read r2 clean
        24'hF20068,   // R8 read r2 reserved set
        24'h800000    // R3 R5 read r0 all zero
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] cmd, input logic [7:0] dat, input int nbits);
        seen = 8'h00;
        csn_pin = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < nbits; i++) begin
            if (i < 8)       sdi_pin = cmd[7-i];
            else if (i < 16) sdi_pin = dat[15-i];
            else             sdi_pin = 1'b1;
            wait_clk(HALF);
            if (i >= 8 && i < 16) seen[15-i] = ~sdo_pull_low;
            sclk_pin = 1'b1;
            wait_clk(HALF);
            sclk_pin = 1'b0;
        end
        wait_clk(HALF);
        tail_pull = sdo_pull_low;
        csn_pin = 1'b1;
        wait_clk(HALF);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);

        // R6 reset state
        chk(reg_flat == '0, "R6 regs", reg_flat[31:0], 0);
        chk(addr_now == 4'h0, "R6 addr", addr_now, 0);
        chk(sdo_pull_low == 1'b0, "R6 sdo", sdo_pull_low, 0);

        for (int v = 0; v < 8; v++) begin
            logic [7:0] c, d, e;
            {c, d, e} = VEC[v];
            xfer(c, d, 16);
            chk(seen == e, "R3 line", seen, e);
            chk(addr_now == c[3:0], "R10 addr", addr_now, c[3:0]);
            chk(tail_pull == 1'b0, "R5 tail", tail_pull, 0);
            if (!c[7])
                chk(reg_flat[c[3:0]*8 +: 8] == d, "R2 store",
                    reg_flat[c[3:0]*8 +: 8], d);
        end
        chk(reg_flat[7:0] == 8'h00 && reg_flat[31:24] == 8'h16, "R8 no alias",
            reg_flat[31:0], 32'h16680000);
        chk(sdo_pull_low == 1'b0, "R4 idle", sdo_pull_low, 0);

        // R7 abort at 12 bits, then full frame decoded from bit 1
        xfer(8'h05, 8'hEE, 12);
        chk(reg_flat[47:40] == 8'h00, "R7 abort", reg_flat[47:40], 0);
        xfer(8'h05, 8'h4B, 16);
        chk(reg_flat[47:40] == 8'h4B, "R7 recover", reg_flat[47:40], 8'h4B);

        // R9 extra clock edges after bit 16
        xfer(8'h06, 8'h29, 20);
        chk(reg_flat[55:48] == 8'h29, "R9 write", reg_flat[55:48], 8'h29);
        xfer(8'h86, 8'h00, 20);
        chk(seen == 8'h29, "R9 read", seen, 8'h29);
        chk(tail_pull == 1'b0, "R9 R5 release", tail_pull, 0);

        // R10 abort before command completes keeps address
        xfer(8'h09, 8'hFF, 4);
        chk(addr_now == 4'h6, "R10 hold", addr_now, 4'h6);
        chk(reg_flat[79:72] == 8'h00, "R7 short", reg_flat[79:72], 0);

        // R4 write frames never pull the line
        xfer(8'h01, 8'h00, 16);
        chk(seen == 8'hFF, "R4 write released", seen, 8'hFF);
        chk(sdo_pull_low == 1'b0, "R4 after", sdo_pull_low, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule